// File: doc/BRIEF.md
# Banked Configuration Port Controller

This block gives a host a two-byte window into a larger configuration space. The low byte address is an index port: the host writes a register number there. The high byte address is a data port, which reads or writes the register that the index selects. Both addresses sit at a base chosen by a parameter, normally 0x2E or 0x4E. After reset the window is locked. Only two back-to-back writes of 0x87 to the index port open it, and a single write of 0xAA to the index port closes it again.

A small set of global registers lives below index 0x30. Index 0x07 is a device-select byte. Indices 0x20 and 0x21 return a 16-bit chip identifier, high byte first, which is fixed by a parameter. Index 0x26 is a spare read/write byte. An access at index 0x30 or above is not served locally. It goes out on a device-side strobe interface that carries the current device-select value and the index, so that the attached device selected by that value answers. That device returns read data in the same cycle.

Host reads have a latency of one cycle. The byte appears on `bus_rdata_o` after the clock edge that samples the read strobe, and it holds until the next decoded read.

Top module: `sio_cfg_port`

## Requirements
- R1: Only host addresses equal to BASE_ADDR (index port) or BASE_ADDR+1 (data port) are decoded. A read or write at any other address changes no state and leaves `bus_rdata_o` unchanged.
- R2: Out of reset the window is locked and `bus_rdata_o` is 0x00. While locked, reads of either port return 0xFF, data-port writes are ignored, and no device strobe is raised.
- R3: The window opens only on the second of two consecutive index-port writes of 0x87. Any other index-port write while locked restarts the sequence. Data-port accesses do not affect the sequence.
- R4: While open, an index-port write of 0xAA locks the window. The index, the device-select and the spare registers keep their values through the lock.
- R5: Data reads at index 0x20 return CHIP_ID[15:8], and data reads at index 0x21 return CHIP_ID[7:0]. Writes to these indices are ignored.
- R6: Index 0x07 (device select) and index 0x26 (spare) are read/write bytes that reset to 0x00.
- R7: While open, a data access at index 0x30..0xFF raises `dev_we_o` or `dev_re_o` for that cycle only. The strobe carries `dev_ldn_o` = device select, `dev_idx_o` = index and `dev_wdata_o` = write byte, and a read returns `dev_rdata_i`. Index 0x2F is not forwarded.
- R8: The index register keeps its value across data accesses. While open, an index-port read returns it.
- R9: Unassigned global indices below 0x30 read as 0x00, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | ADDR_W | Host byte address |
| bus_we_i | input | 1 | Host write strobe, one cycle per write |
| bus_re_i | input | 1 | Host read strobe, one cycle per read |
| bus_wdata_i | input | 8 | Host write byte |
| bus_rdata_o | output | 8 | Host read byte, valid the cycle after the read strobe |
| dev_we_o | output | 1 | Forwarded write strobe for banked indices |
| dev_re_o | output | 1 | Forwarded read strobe for banked indices |
| dev_ldn_o | output | 8 | Device-select value for the forwarded access |
| dev_idx_o | output | 8 | Register index for the forwarded access |
| dev_wdata_o | output | 8 | Forwarded write byte |
| dev_rdata_i | input | 8 | Read byte returned by the selected device in the same cycle |

## Verification
The bench attacks the unlock sequence. It interleaves 0x87 with other index values and with data reads. A design that counts 0x87 writes that are not adjacent would open too early, and one that lets data reads break the pair would stay shut. It probes the bank boundary at 0x2F and 0x30 and the top index 0xFF; an off-by-one compare would forward a global access or swallow a device one. It also writes the exit code to an address that is not decoded, and it tries writes to the read-only identifier and to data ports while locked. A design with loose address decode or a missing lock gate would then show unexpected device strobes or altered read-back.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  typedef enum logic [1:0] {ST_LOCKED, ST_ARMED, ST_OPEN} lock_st_e;

  localparam logic [7:0] KEY_ENTER     = 8'h87;
  localparam logic [7:0] KEY_EXIT      = 8'hAA;
  localparam logic [7:0] IDX_LDN       = 8'h07;
  localparam logic [7:0] IDX_ID_HI     = 8'h20;
  localparam logic [7:0] IDX_ID_LO     = 8'h21;
  localparam logic [7:0] IDX_SPARE     = 8'h26;
  localparam logic [7:0] IDX_BANK_BASE = 8'h30;
  localparam logic [7:0] RD_LOCKED     = 8'hFF;
endpackage

// File: rtl/sio_unlock_fsm.sv
module sio_unlock_fsm
  import sio_cfg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       idx_wr_i,
  input  logic [7:0] wdata_i,
  output logic       open_o,
  output lock_st_e   state_o
);
  lock_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (idx_wr_i) begin
      unique case (st_q)
        ST_LOCKED: st_d = (wdata_i == KEY_ENTER) ? ST_ARMED : ST_LOCKED;
        ST_ARMED:  st_d = (wdata_i == KEY_ENTER) ? ST_OPEN  : ST_LOCKED;
        ST_OPEN:   st_d = (wdata_i == KEY_EXIT)  ? ST_LOCKED : ST_OPEN;
        default:   st_d = ST_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_LOCKED;
    else         st_q <= st_d;
  end

  assign open_o  = (st_q == ST_OPEN);
  assign state_o = st_q;
endmodule

// File: rtl/sio_global_regs.sv
module sio_global_regs
  import sio_cfg_pkg::*;
#(
  parameter logic [15:0] CHIP_ID = 16'h5A17
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] idx_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic [7:0] ldn_o
);
  logic [7:0] ldn_q, spare_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ldn_q   <= '0;
      spare_q <= '0;
    end else if (wr_i) begin
      if (idx_i == IDX_LDN)   ldn_q   <= wdata_i;
      if (idx_i == IDX_SPARE) spare_q <= wdata_i;
    end
  end

  always_comb begin
    unique case (idx_i)
      IDX_LDN:   rdata_o = ldn_q;
      IDX_ID_HI: rdata_o = CHIP_ID[15:8];
      IDX_ID_LO: rdata_o = CHIP_ID[7:0];
      IDX_SPARE: rdata_o = spare_q;
      default:   rdata_o = '0;
    endcase
  end

  assign ldn_o = ldn_q;
endmodule

// File: rtl/sio_bank_router.sv
module sio_bank_router
  import sio_cfg_pkg::*;
(
  input  logic       open_i,
  input  logic       data_wr_i,
  input  logic       data_rd_i,
  input  logic [7:0] idx_i,
  output logic       bank_sel_o,
  output logic       glb_wr_o,
  output logic       dev_we_o,
  output logic       dev_re_o
);
  assign bank_sel_o = (idx_i >= IDX_BANK_BASE);
  assign glb_wr_o   = open_i && data_wr_i && !bank_sel_o;
  assign dev_we_o   = open_i && data_wr_i &&  bank_sel_o;
  assign dev_re_o   = open_i && data_rd_i &&  bank_sel_o;
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] BASE_ADDR = 16'h002E,
  parameter logic [15:0] CHIP_ID   = 16'h5A17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  input  logic [7:0]        bus_wdata_i,
  output logic [7:0]        bus_rdata_o,
  output logic              dev_we_o,
  output logic              dev_re_o,
  output logic [7:0]        dev_ldn_o,
  output logic [7:0]        dev_idx_o,
  output logic [7:0]        dev_wdata_o,
  input  logic [7:0]        dev_rdata_i
);
  localparam logic [ADDR_W-1:0] BASE_W = ADDR_W'(BASE_ADDR);

  logic       hit, port_sel;
  logic       idx_wr, idx_rd, data_wr, data_rd;
  logic       win_open, bank_sel, glb_wr;
  lock_st_e   lock_st;
  logic [7:0] idx_q, glb_rdata, ldn, rd_d, rdata_q;

  // pair decode: bit 0 picks index/data
  assign hit      = (bus_addr_i[ADDR_W-1:1] == BASE_W[ADDR_W-1:1]);
  assign port_sel = bus_addr_i[0];
  assign idx_wr   = bus_we_i && hit && !port_sel;
  assign data_wr  = bus_we_i && hit &&  port_sel;
  assign idx_rd   = bus_re_i && hit && !port_sel;
  assign data_rd  = bus_re_i && hit &&  port_sel;

  sio_unlock_fsm i_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .idx_wr_i(idx_wr),
    .wdata_i (bus_wdata_i),
    .open_o  (win_open),
    .state_o (lock_st)
  );

  sio_bank_router i_router (
    .open_i    (win_open),
    .data_wr_i (data_wr),
    .data_rd_i (data_rd),
    .idx_i     (idx_q),
    .bank_sel_o(bank_sel),
    .glb_wr_o  (glb_wr),
    .dev_we_o  (dev_we_o),
    .dev_re_o  (dev_re_o)
  );

  sio_global_regs #(.CHIP_ID(CHIP_ID)) i_glb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (glb_wr),
    .idx_i  (idx_q),
    .wdata_i(bus_wdata_i),
    .rdata_o(glb_rdata),
    .ldn_o  (ldn)
  );

  // index captured only while open; exit code is not stored
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                          idx_q <= '0;
    else if (idx_wr && win_open && bus_wdata_i != KEY_EXIT) idx_q <= bus_wdata_i;
  end

  always_comb begin
    if (!win_open)     rd_d = RD_LOCKED;
    else if (!port_sel) rd_d = idx_q;
    else if (bank_sel)  rd_d = dev_rdata_i;
    else                rd_d = glb_rdata;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rdata_q <= '0;
    else if (bus_re_i && hit)  rdata_q <= rd_d;
  end

  assign bus_rdata_o = rdata_q;
  assign dev_ldn_o   = ldn;
  assign dev_idx_o   = idx_q;
  assign dev_wdata_o = bus_wdata_i;
endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk
  import sio_cfg_pkg::*;
#(
  parameter logic [15:0] CHIP_ID = 16'h5A17
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       idx_wr,
  input logic       data_wr,
  input logic       data_rd,
  input logic [7:0] bus_wdata_i,
  input logic [7:0] bus_rdata_o,
  input logic       win_open,
  input lock_st_e   lock_st,
  input logic [7:0] idx_q,
  input logic       dev_we_o,
  input logic       dev_re_o,
  input logic [7:0] dev_idx_o
);
  AST_LOCKED_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_open |-> (!dev_we_o && !dev_re_o)); // R2

  AST_LOCKED_READ_FF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd && !win_open) |=> (bus_rdata_o == RD_LOCKED)); // R2

  AST_OPEN_NEEDS_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(win_open) |-> ($past(lock_st) == ST_ARMED && $past(idx_wr) && $past(bus_wdata_i) == KEY_ENTER)); // R3

  AST_EXIT_LOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_open && idx_wr && bus_wdata_i == KEY_EXIT) |=> !win_open); // R4

  AST_ID_HI_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_open && data_rd && idx_q == IDX_ID_HI) |=> (bus_rdata_o == CHIP_ID[15:8])); // R5

  AST_FWD_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_we_o || dev_re_o) |-> (dev_idx_o >= IDX_BANK_BASE)); // R7

  AST_IDX_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr || data_rd) && !idx_wr |=> $stable(idx_q)); // R8
endmodule

bind sio_cfg_port sio_cfg_port_chk #(.CHIP_ID(CHIP_ID)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .idx_wr     (idx_wr),
  .data_wr    (data_wr),
  .data_rd    (data_rd),
  .bus_wdata_i(bus_wdata_i),
  .bus_rdata_o(bus_rdata_o),
  .win_open   (win_open),
  .lock_st    (lock_st),
  .idx_q      (idx_q),
  .dev_we_o   (dev_we_o),
  .dev_re_o   (dev_re_o),
  .dev_idx_o  (dev_idx_o)
);

// File: tb/test_sio_cfg_port.sv
`timescale 1ns/1ps
module test_sio_cfg_port;
  localparam logic [15:0] BASE = 16'h002E;
  localparam logic [15:0] CID  = 16'h5A17;
  localparam logic [15:0] IDXP = BASE;
  localparam logic [15:0] DATP = BASE + 16'd1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic we = 1'b0, re = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic dev_we, dev_re;
  logic [7:0] dev_ldn, dev_idx, dev_wdata, dev_rdata;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] last_rd = 8'h00;

  logic [7:0]  exp_rd_q[$];
  string       rd_tag_q[$];
  logic [23:0] exp_dw_q[$];
  string       dw_tag_q[$];

  always #10 clk = ~clk;

  function automatic logic [7:0] dev_model(input logic [7:0] l, input logic [7:0] i);
    return l ^ i ^ 8'h5A;
  endfunction
  assign dev_rdata = dev_model(dev_ldn, dev_idx);

  sio_cfg_port #(.ADDR_W(16), .BASE_ADDR(BASE), .CHIP_ID(CID)) i_sio_cfg_port (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we), .bus_re_i(re),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .dev_we_o(dev_we), .dev_re_o(dev_re),
    .dev_ldn_o(dev_ldn), .dev_idx_o(dev_idx), .dev_wdata_o(dev_wdata), .dev_rdata_i(dev_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] e, input string tag);
    exp_rd_q.push_back(e); rd_tag_q.push_back(tag); last_rd = e;
    @(negedge clk); addr = a; re = 1'b1;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic expect_dw(input logic [7:0] l, input logic [7:0] i, input logic [7:0] d, input string tag);
    exp_dw_q.push_back({l, i, d}); dw_tag_q.push_back(tag);
  endtask

  // read monitor
  initial forever begin
    @(posedge clk);
    if (rst_n && re) begin
      @(negedge clk);
      if (exp_rd_q.size() == 0) chk("read with no expectation", 32'd1, 32'd0);
      else chk(rd_tag_q.pop_front(), {24'd0, rdata}, {24'd0, exp_rd_q.pop_front()});
    end
  end

  // device write monitor
  always @(posedge clk) begin
    if (rst_n && dev_we) begin
      if (exp_dw_q.size() == 0) chk("R2/R7 unexpected dev write", {8'd0, dev_ldn, dev_idx, dev_wdata}, 32'd0);
      else chk(dw_tag_q.pop_front(), {8'd0, dev_ldn, dev_idx, dev_wdata}, {8'd0, exp_dw_q.pop_front()});
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R2 reset rdata", {24'd0, rdata}, 32'h00);
    chk("R2 reset strobes", {30'd0, dev_we, dev_re}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // locked behaviour
    rd(DATP, 8'hFF, "R2 locked data read");
    rd(IDXP, 8'hFF, "R2 locked index read");
    wr(IDXP, 8'h30);
    wr(DATP, 8'h11);                              // no dev write expected, R2
    // broken sequences, R3
    wr(IDXP, 8'h87); wr(IDXP, 8'h12); wr(IDXP, 8'h87);
    rd(DATP, 8'hFF, "R3 armed still locked");     // data read keeps ARMED
    wr(IDXP, 8'h13);
    wr(IDXP, 8'h87);
    rd(DATP, 8'hFF, "R3 one key not enough");
    wr(IDXP, 8'h87);
    wr(IDXP, 8'h00);
    rd(IDXP, 8'h00, "R3 opened after pair");

    // chip id, R5
    wr(IDXP, 8'h20); rd(DATP, CID[15:8], "R5 id high");
    wr(IDXP, 8'h21); rd(DATP, CID[7:0], "R5 id low");
    wr(DATP, 8'h00); rd(DATP, CID[7:0], "R5 id read-only");

    // spare + index hold, R6 R8
    wr(IDXP, 8'h26); rd(DATP, 8'h00, "R6 spare reset value");
    wr(DATP, 8'hA5); rd(DATP, 8'hA5, "R6 spare write");
    rd(DATP, 8'hA5, "R8 index held across reads");
    rd(IDXP, 8'h26, "R8 index readback");

    // unassigned globals, R9
    wr(IDXP, 8'h2F); rd(DATP, 8'h00, "R9 unassigned reads zero");
    wr(DATP, 8'h77); rd(DATP, 8'h00, "R9 unassigned write ignored"); // R7 boundary: 0x2F not forwarded

    // device select and forwarding, R6 R7
    wr(IDXP, 8'h07); wr(DATP, 8'h03); rd(DATP, 8'h03, "R6 ldn write");
    wr(IDXP, 8'h30);
    expect_dw(8'h03, 8'h30, 8'h9C, "R7 forward write base");
    wr(DATP, 8'h9C);
    rd(DATP, dev_model(8'h03, 8'h30), "R7 forward read base");
    wr(IDXP, 8'h07); wr(DATP, 8'h0B);
    wr(IDXP, 8'hFF);
    expect_dw(8'h0B, 8'hFF, 8'h41, "R7 forward write top");
    wr(DATP, 8'h41);
    rd(DATP, dev_model(8'h0B, 8'hFF), "R7 forward read top");

    // address decode, R1
    wr(16'h004E, 8'hAA);
    wr(16'h0030, 8'h07);
    rd(DATP, dev_model(8'h0B, 8'hFF), "R1 foreign writes ignored");
    exp_rd_q.push_back(last_rd); rd_tag_q.push_back("R1 foreign read keeps rdata");
    @(negedge clk); addr = 16'h002C; re = 1'b1; @(negedge clk); re = 1'b0;

    // exit, R4
    wr(IDXP, 8'hAA);
    rd(DATP, 8'hFF, "R4 locked after exit");
    wr(DATP, 8'h55);
    wr(IDXP, 8'h87); wr(IDXP, 8'h87);
    rd(IDXP, 8'hFF, "R4 index kept through lock");
    wr(IDXP, 8'h07); rd(DATP, 8'h0B, "R4 ldn kept through lock");
    wr(IDXP, 8'h26); rd(DATP, 8'hA5, "R4 spare kept through lock");

    repeat (4) @(negedge clk);
    chk("R7 pending dev writes", exp_dw_q.size(), 0);
    chk("pending reads", exp_rd_q.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule